// File: doc/BRIEF.md
# Predicated Sub-Vector Element Loop Sequencer

This block produces the sequence of element positions for one scalar operation that the core repeats over a vector. A start pulse captures the vector length, the requested sub-vector length (1 to 4), one predicate bit per element group, and a fail-on-first mode. The sequencer then walks two nested loops. The inner loop counts sub-elements inside a group while the outer element offset holds. The outer offset moves on only after the whole group has finished. Each predicate bit covers one whole group. A group whose bit is clear issues nothing, but it still takes one cycle while its offset passes.

The outgoing steps form a valid/ready stream. The offsets and `step_valid_o` stay fixed until the consumer raises `step_ready_i`. The consumer returns `step_fail_i` in the same cycle it accepts a step, and the sequencer samples it only on that handshake. In conditional fail-on-first mode, a fail ends the operation and the new vector length becomes the count of groups before the failing group. In trap mode, the same truncation applies to every group except element group 0: a fail there is reported as an ordinary trap and the length is left unchanged. The sequencer never rewrites the sub-vector length. A sub-vector length outside 1 to 4 raises an exception, and the operation does not start.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, `step_valid_o`, `done_o`, `trap_o` and `subvl_exc_o` are 0, and both offsets and `vl_new_o` are 0.
- R2: A start with `subvl_i` equal to 0, 5, 6 or 7 pulses `subvl_exc_o` for one cycle, starting the cycle after the start. No step is issued and `done_o` does not assert. The values 1 to 4 are accepted.
- R3: Steps are issued in order of ascending element offset. Within each element, the sub-offset runs 0 to SUBVL-1 before the element offset advances.
- R4: Bit e of `pred_mask_i` gates group e. When the bit is 0, no step of that group is issued, and the group occupies exactly one cycle.
- R5: While `step_valid_o` is 1 and `step_ready_i` is 0, the step stays valid and both offsets hold their values.
- R6: `done_o` pulses for one cycle, in the cycle after the last group finishes or the loop is cut short. In that cycle both offsets read 0. Without truncation, `vl_new_o` equals the requested VL.
- R7: In conditional mode (`ff_mode_i`=2), a fail on any sub-element of group e stops issuing and sets `vl_new_o` to e, even when earlier sub-elements of that group passed.
- R8: In trap mode (`ff_mode_i`=1), a fail in group 0 pulses `trap_o` together with `done_o` and leaves `vl_new_o` equal to VL. A fail in a later group e gives no trap and sets `vl_new_o` to e.
- R9: Masked-out groups that come before a fail are counted in the truncated `vl_new_o`.
- R10: When VL=1 and SUBVL=1, exactly one step (0,0) is issued, followed by `done_o` with `vl_new_o`=1.
- R11: In mode 0 (and the unused mode 3), `step_fail_i` is ignored and every enabled step is issued.
- R12: A start with VL=0 issues no step and pulses `done_o` in the next cycle with `vl_new_o`=0.
- R13: `start_i` is ignored while an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| vl_i | input | 6 | Vector length in groups |
| subvl_i | input | 3 | Requested sub-vector length |
| ff_mode_i | input | 2 | 0 off, 1 trap fail-on-first, 2 conditional fail-on-first |
| pred_mask_i | input | 64 | One predicate bit per group |
| step_valid_o | output | 1 | A step is offered |
| step_ready_i | input | 1 | Consumer accepts the offered step |
| step_fail_i | input | 1 | Fault or zero result of the accepted step |
| elem_off_o | output | 6 | Element (group) offset |
| sub_off_o | output | 2 | Sub-element offset |
| done_o | output | 1 | Operation finished (one cycle) |
| vl_new_o | output | 6 | Resulting vector length |
| trap_o | output | 1 | Normal trap from group 0 (with done) |
| subvl_exc_o | output | 1 | Illegal sub-vector length |

## Verification
Normal completion and fail-on-first truncation can both fall due in the same cycle. This happens when the fail arrives on the very last sub-element of the last group. The bench provokes this in conditional mode with VL=3 and SUBVL=2, failing step (2,1). It expects `vl_new_o`=2 rather than 3, which shows that truncation takes precedence. The bench also uses alternating ready, so that back-pressure and masked-group skipping overlap.

// File: rtl/seqloop_pkg.sv
package seqloop_pkg;
  typedef enum logic [1:0] {FF_OFF = 2'd0, FF_TRAP = 2'd1, FF_COND = 2'd2, FF_RSVD = 2'd3} ff_mode_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/subvl_decode.sv
module subvl_decode #(
  parameter int SW = 2
) (
  input  logic [SW:0]   req_i,
  output logic          legal_o,
  output logic [SW-1:0] code_o
);
  localparam logic [SW:0] ONE    = (SW+1)'(1);
  localparam logic [SW:0] MAXSUB = (SW+1)'(2**SW);

  always_comb begin
    legal_o = (req_i != '0) && (req_i <= MAXSUB);
    code_o  = SW'(req_i - ONE);
  end
endmodule

// File: rtl/group_counter.sv
module group_counter #(
  parameter int EW = 6,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          next_grp_i,
  input  logic          next_sub_i,
  output logic [EW-1:0] elem_o,
  output logic [SW-1:0] sub_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_o <= '0;
      sub_o  <= '0;
    end else if (clear_i) begin
      elem_o <= '0;
      sub_o  <= '0;
    end else if (next_grp_i) begin
      elem_o <= elem_o + EW'(1);
      sub_o  <= '0;
    end else if (next_sub_i) begin
      sub_o  <= sub_o + SW'(1);
    end
  end

  // R3
  sub_hold_on_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_grp_i && !clear_i) |=> (sub_o == '0));
endmodule

// File: rtl/ff_resolver.sv
module ff_resolver #(
  parameter int EW = 6
) (
  input  seqloop_pkg::ff_mode_e mode_i,
  input  logic                  fail_i,
  input  logic [EW-1:0]         elem_i,
  input  logic [EW-1:0]         vl_i,
  output logic                  stop_o,
  output logic                  trap_o,
  output logic [EW-1:0]         vl_o
);
  import seqloop_pkg::*;

  logic armed;
  always_comb begin
    armed  = (mode_i == FF_TRAP) || (mode_i == FF_COND);
    stop_o = fail_i && armed;
    trap_o = fail_i && (mode_i == FF_TRAP) && (elem_i == '0);
    vl_o   = trap_o ? vl_i : elem_i;
  end
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
  parameter int EW = 6,
  parameter int SW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [EW-1:0]    vl_i,
  input  logic [SW:0]      subvl_i,
  input  logic [1:0]       ff_mode_i,
  input  logic [2**EW-1:0] pred_mask_i,
  output logic             step_valid_o,
  input  logic             step_ready_i,
  input  logic             step_fail_i,
  output logic [EW-1:0]    elem_off_o,
  output logic [SW-1:0]    sub_off_o,
  output logic             done_o,
  output logic [EW-1:0]    vl_new_o,
  output logic             trap_o,
  output logic             subvl_exc_o
);
  import seqloop_pkg::*;

  localparam int NGRP = 2**EW;

  seq_state_e      state_q;
  logic [EW-1:0]   vl_q;
  logic [SW-1:0]   code_q;
  logic [NGRP-1:0] mask_q;
  ff_mode_e        mode_q;

  logic            sv_legal;
  logic [SW-1:0]   sv_code;
  logic            running, grp_on, last_sub, last_grp, hs, grp_end;
  logic            ff_stop, ff_trap, finish_norm;
  logic            clr, nxt_grp, nxt_sub;
  logic [EW-1:0]   ff_vl;

  subvl_decode #(.SW(SW)) u_dec (
    .req_i(subvl_i), .legal_o(sv_legal), .code_o(sv_code)
  );

  group_counter #(.EW(EW), .SW(SW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(clr), .next_grp_i(nxt_grp),
    .next_sub_i(nxt_sub), .elem_o(elem_off_o), .sub_o(sub_off_o)
  );

  ff_resolver #(.EW(EW)) u_ff (
    .mode_i(mode_q), .fail_i(hs && step_fail_i), .elem_i(elem_off_o),
    .vl_i(vl_q), .stop_o(ff_stop), .trap_o(ff_trap), .vl_o(ff_vl)
  );

  always_comb begin
    running      = (state_q == ST_RUN);
    grp_on       = mask_q[elem_off_o];
    last_sub     = (sub_off_o == code_q);
    last_grp     = (elem_off_o == vl_q - EW'(1));
    step_valid_o = running && grp_on;
    hs           = step_valid_o && step_ready_i;
    grp_end      = running && ((hs && last_sub) || !grp_on);
    finish_norm  = grp_end && last_grp && !ff_stop;
    clr          = ff_stop || finish_norm;
    nxt_grp      = grp_end && !last_grp && !ff_stop;
    nxt_sub      = hs && !last_sub && !ff_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      vl_q        <= '0;
      code_q      <= '0;
      mask_q      <= '0;
      mode_q      <= FF_OFF;
      done_o      <= 1'b0;
      trap_o      <= 1'b0;
      subvl_exc_o <= 1'b0;
      vl_new_o    <= '0;
    end else begin
      done_o      <= 1'b0;
      trap_o      <= 1'b0;
      subvl_exc_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          if (!sv_legal) begin
            subvl_exc_o <= 1'b1;
          end else if (vl_i == '0) begin
            done_o   <= 1'b1;
            vl_new_o <= '0;
          end else begin
            state_q <= ST_RUN;
            vl_q    <= vl_i;
            code_q  <= sv_code;
            mask_q  <= pred_mask_i;
            mode_q  <= ff_mode_e'(ff_mode_i);
          end
        end
      end else if (ff_stop) begin
        state_q  <= ST_IDLE;
        done_o   <= 1'b1;
        trap_o   <= ff_trap;
        vl_new_o <= ff_vl;
      end else if (finish_norm) begin
        state_q  <= ST_IDLE;
        done_o   <= 1'b1;
        vl_new_o <= vl_q;
      end
    end
  end

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid_o && !step_ready_i) |=> (step_valid_o && $stable(elem_off_o) && $stable(sub_off_o)));

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_sub && !step_fail_i) |=> (sub_off_o == $past(sub_off_o) + SW'(1)));

  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (elem_off_o == '0 && sub_off_o == '0 && !step_valid_o));

  // R2
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subvl_exc_o |-> (!step_valid_o && !done_o));

  // R8
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> done_o);

  // R4
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !grp_on && !last_grp) |=> (elem_off_o == $past(elem_off_o) + EW'(1)));
endmodule

// File: tb/tb_elem_loop_seq.sv
module tb_elem_loop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  vl_i = '0;
  logic [2:0]  subvl_i = '0;
  logic [1:0]  ff_mode_i = '0;
  logic [63:0] pred_mask_i = '0;
  logic        step_ready_i = 1'b0;
  logic        step_fail_i = 1'b0;
  logic        step_valid_o, done_o, trap_o, subvl_exc_o;
  logic [5:0]  elem_off_o, vl_new_o;
  logic [1:0]  sub_off_o;

  always #2.5 clk = ~clk;

  elem_loop_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
    .ff_mode_i(ff_mode_i), .pred_mask_i(pred_mask_i), .step_valid_o(step_valid_o),
    .step_ready_i(step_ready_i), .step_fail_i(step_fail_i), .elem_off_o(elem_off_o),
    .sub_off_o(sub_off_o), .done_o(done_o), .vl_new_o(vl_new_o), .trap_o(trap_o),
    .subvl_exc_o(subvl_exc_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] expq[$];
  string cur_tag = "R1";
  int  fail_e = -1, fail_s = -1;
  bit  rdy_alt = 0;
  bit  done_seen = 0, trap_seen = 0, exc_seen = 0;
  int  cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor and response driver
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      step_ready_i = rdy_alt ? cyc[0] : 1'b1;
      step_fail_i  = step_valid_o && (int'(elem_off_o) == fail_e) && (int'(sub_off_o) == fail_s);
      if (step_valid_o && step_ready_i) begin
        if (expq.size() == 0) begin
          chk({cur_tag, " unexpected step"}, {elem_off_o, sub_off_o}, -1);
        end else begin
          chk({cur_tag, " step"}, {elem_off_o, sub_off_o}, expq.pop_front());
        end
      end
      if (done_o) begin
        done_seen = 1;
        trap_seen = trap_o;
        chk("R6 offsets zero at done", {elem_off_o, sub_off_o}, 0);
      end
      if (subvl_exc_o) exc_seen = 1;
    end
  end

  task automatic run_op(input string tag, input int vl, input int sv, input logic [63:0] m,
                        input int md, input int fe, input int fs, input bit alt, input bit hold);
    int exp_vl = vl;
    bit exp_trap = 0;
    bit stop = 0;
    expq.delete();
    for (int e = 0; e < vl && !stop; e++) begin
      if (m[e]) begin
        for (int s = 0; s < sv && !stop; s++) begin
          expq.push_back({6'(e), 2'(s)});
          if ((md == 1 || md == 2) && e == fe && s == fs) begin
            stop = 1;
            if (md == 1 && e == 0) exp_trap = 1;
            else exp_vl = e;
          end
        end
      end
    end
    @(negedge clk);
    cur_tag = tag; fail_e = fe; fail_s = fs; rdy_alt = alt;
    done_seen = 0; trap_seen = 0; exc_seen = 0;
    vl_i = 6'(vl); subvl_i = 3'(sv); ff_mode_i = 2'(md); pred_mask_i = m;
    start_i = 1'b1;
    if (hold) begin
      @(negedge clk); vl_i = 6'd9;
      @(negedge clk);
    end
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 600 && !done_seen; k++) @(negedge clk);
    chk({tag, " done seen"}, int'(done_seen), 1);
    chk({tag, " remaining steps"}, expq.size(), 0);
    chk({tag, " vl_new"}, int'(vl_new_o), exp_vl);
    chk({tag, " trap"}, int'(trap_seen), int'(exp_trap));
    chk({tag, " no exception"}, int'(exc_seen), 0);
    @(negedge clk);
  endtask

  task automatic bad_subvl(input int sv);
    expq.delete();
    @(negedge clk);
    cur_tag = "R2"; done_seen = 0; exc_seen = 0; fail_e = -1;
    vl_i = 6'd3; subvl_i = 3'(sv); ff_mode_i = 2'd0; pred_mask_i = '1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 exception pulse", int'(subvl_exc_o), 1);
    repeat (6) @(negedge clk);
    chk("R2 exception seen", int'(exc_seen), 1);
    chk("R2 no done", int'(done_seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(step_valid_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 offsets", {elem_off_o, sub_off_o}, 0);
    chk("R1 vl_new", int'(vl_new_o), 0);
    chk("R1 exc", int'(subvl_exc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R3 R6 full",          4, 3, '1,             0, -1, -1, 0, 0);
    run_op("R4 R5 masked stall",  6, 2, 64'b101101,     0, -1, -1, 1, 0);
    run_op("R10 scalar",          1, 1, '1,             0, -1, -1, 0, 0);
    run_op("R7 R9 cond",          8, 4, 64'hFD,         2,  3,  2, 0, 0);
    run_op("R7 cond last step",   3, 2, '1,             2,  2,  1, 1, 0);
    run_op("R8 trap first group", 5, 2, '1,             1,  0,  1, 0, 0);
    run_op("R8 R9 trap later",    7, 1, 64'b1111011,    1,  4,  0, 1, 0);
    run_op("R11 mode off",        5, 4, '1,             0,  2,  0, 0, 0);
    run_op("R11 mode rsvd",       3, 2, '1,             3,  1,  1, 0, 0);
    run_op("R2 subvl4 legal",     2, 4, '1,             0, -1, -1, 0, 0);
    run_op("R12 vl zero",         0, 2, '1,             0, -1, -1, 0, 0);
    run_op("R13 start while busy",3, 2, '1,             0, -1, -1, 0, 1);
    bad_subvl(0);
    bad_subvl(5);
    bad_subvl(7);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule